// File: doc/BRIEF.md
# Privileged Coprocessor Instruction Decoder

This block takes one 32-bit instruction word that earlier logic has already classed as a system-coprocessor or cache operation. Together with the word it receives a kernel-mode flag and the 64-bit value of the instruction's source register. It checks privilege, then decodes the word into exactly one action. The action is one of: a coprocessor register read, a coprocessor register write, exception return, one of four TLB operations, or an error indication. The register file, the TLB and the caches sit outside the block. They react to the strobes it drives.

Instructions enter through a valid/ready handshake. The handshake has one register stage, so an accepted word is held until the consumer takes the result.
- A register read happens combinationally in the cycle the word is accepted. The read data is captured into the stage.
- Every action strobe and error indication is a one-cycle pulse. It is raised only in the cycle the result handshake completes.
- Back-pressure follows this rule: `in_ready` is high when the stage is empty or its result is being taken in the same cycle.
- While `out_valid` is high and `out_ready` is low, the held result stays unchanged and no pulse is raised.

Top module: `priv_cop_decoder`

## Requirements
- R1: When `in_kernel` is 0, an accepted word produces only `cpu_unusable`. There is no register read, no write request, no other strobe and no error.
- R2: Opcode bits 31:26 = 010000 with rs bits 25:21 = 00000 or 00001 is a move-from. In the accept cycle it raises `rd_en` with `rd_idx` = bits 15:11. The `rd_data` sampled in that cycle is returned as `out_dest`, with `out_dest_vld` high while the result is held.
- R3: rs = 00100 is a 32-bit move-to. It requests a write to index bits 15:11 with data equal to source bits 31:0 sign-extended to 64 bits, and with `wr_dword` = 0.
- R4: rs = 00101 is a doubleword move-to. It requests a write of the unchanged source value with `wr_dword` = 1.
- R5: When rs bit 4 is 1, function bits 5:0 = 011000 is exception return. It pulses `eret_stb` together with `llc_stb`, which clears the load-linked bit.
- R6: When rs bit 4 is 1, the function codes pulse these strobes:

  | Function code | Strobe |
  |---|---|
  | 001000 | `tlbp_stb` |
  | 000001 | `tlbr_stb` |
  | 000010 | `tlbwi_stb` |
  | 000110 | `tlbwr_stb` |

- R7: The following raise `illegal_op`:
  - the old return function 010000;
  - the branch sub-opcode rs = 01000;
  - any other unlisted rs value;
  - any other function code.
- R8: Opcode 101111 (cache) raises `cache_unsup` for every target code in bits 17:16 (00, 01, 10, 11). Any opcode other than 010000 or 101111 raises `illegal_op`.
- R9: `in_ready` equals `!out_valid || out_ready`. While a result is stalled, `out_valid` and `out_dest` hold and no pulse is raised. Each accepted word yields its pulses exactly once, in its handshake cycle.
- R10: Per decoded word, at most one of these asserts: a strobe, a write request, a read result or an error. `llc_stb` only accompanies `eret_stb`.
- R11: During reset, `out_valid` is 0 and every pulse output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Stage can accept a word |
| in_instr | input | 32 | Instruction word |
| in_kernel | input | 1 | Processor is in kernel mode |
| in_src | input | XLEN | Source register value |
| rd_en | output | 1 | Coprocessor register read enable |
| rd_idx | output | 5 | Register index to read |
| rd_data | input | XLEN | Read data, same cycle as `rd_en` |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_dest | output | XLEN | Destination value of a move-from |
| out_dest_vld | output | 1 | `out_dest` carries read data |
| wr_req | output | 1 | Register write request pulse |
| wr_idx | output | 5 | Register index to write |
| wr_data | output | XLEN | Write data |
| wr_dword | output | 1 | Write came from the doubleword move |
| eret_stb | output | 1 | Exception return pulse |
| llc_stb | output | 1 | Load-linked clear pulse |
| tlbp_stb | output | 1 | TLB probe pulse |
| tlbr_stb | output | 1 | TLB read pulse |
| tlbwi_stb | output | 1 | Indexed TLB write pulse |
| tlbwr_stb | output | 1 | Random TLB write pulse |
| cpu_unusable | output | 1 | Coprocessor-unusable pulse |
| illegal_op | output | 1 | Illegal operation pulse |
| cache_unsup | output | 1 | Unsupported cache operation pulse |

## Verification
The bench builds the block with the default XLEN of 64. This makes the upper half of a 32-bit move-to visible. Both a zero-filled and a one-filled extension are driven, each with junk in the source's upper word.

The same instruction list runs twice:
- once with `out_ready` driven from a pseudo-random sequence, which reaches stalls, held results and accepts that fall in the same cycle as a result leaves;
- once with `out_ready` tied high, which reaches back-to-back accepts.

The register file is modelled so that every index returns a distinct value. This exposes a wrong `rd_idx`.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int IDX_W = 5;

  localparam logic [5:0] OPC_COP   = 6'b010000;
  localparam logic [5:0] OPC_CACHE = 6'b101111;

  localparam logic [4:0] RS_MF  = 5'b00000;
  localparam logic [4:0] RS_DMF = 5'b00001;
  localparam logic [4:0] RS_MT  = 5'b00100;
  localparam logic [4:0] RS_DMT = 5'b00101;

  localparam logic [5:0] FN_TLBR  = 6'b000001;
  localparam logic [5:0] FN_TLBWI = 6'b000010;
  localparam logic [5:0] FN_TLBWR = 6'b000110;
  localparam logic [5:0] FN_TLBP  = 6'b001000;
  localparam logic [5:0] FN_ERET  = 6'b011000;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_READ,
    ACT_WR32,
    ACT_WR64,
    ACT_ERET,
    ACT_TLBP,
    ACT_TLBR,
    ACT_TLBWI,
    ACT_TLBWR,
    ACT_UNUSABLE,
    ACT_ILLEGAL,
    ACT_CACHE
  } act_e;

endpackage

// File: rtl/pcd_decode.sv
module pcd_decode
  import pcd_pkg::*;
(
  input  logic [31:0]      instr,
  input  logic             kernel,
  output act_e             act,
  output logic [IDX_W-1:0] idx
);

  logic [5:0] opc;
  logic [4:0] rs;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign rs  = instr[25:21];
  assign fn  = instr[5:0];
  assign idx = instr[15:11];

  always_comb begin
    act = ACT_ILLEGAL;
    if (!kernel) begin
      act = ACT_UNUSABLE;
    end else if (opc == OPC_COP) begin
      if (rs[4]) begin
        unique case (fn)
          FN_ERET:  act = ACT_ERET;
          FN_TLBP:  act = ACT_TLBP;
          FN_TLBR:  act = ACT_TLBR;
          FN_TLBWI: act = ACT_TLBWI;
          FN_TLBWR: act = ACT_TLBWR;
          default:  act = ACT_ILLEGAL;
        endcase
      end else begin
        unique case (rs)
          RS_MF, RS_DMF: act = ACT_READ;
          RS_MT:         act = ACT_WR32;
          RS_DMT:        act = ACT_WR64;
          default:       act = ACT_ILLEGAL;
        endcase
      end
    end else if (opc == OPC_CACHE) begin
      act = ACT_CACHE;
    end
  end

endmodule

// File: rtl/pcd_sext.sv
module pcd_sext #(
  parameter int XLEN     = 64,
  parameter int NARROW_W = 32
) (
  input  logic [XLEN-1:0] src,
  input  logic            dword,
  output logic [XLEN-1:0] wdata
);

  logic [XLEN-1:0] narrow;

  generate
    if (XLEN > NARROW_W) begin : g_extend
      assign narrow = {{(XLEN-NARROW_W){src[NARROW_W-1]}}, src[NARROW_W-1:0]};
    end else begin : g_same
      assign narrow = src;
    end
  endgenerate

  assign wdata = dword ? src : narrow;

endmodule

// File: rtl/pcd_stage.sv
module pcd_stage
  import pcd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  act_e             act_d,
  input  logic [IDX_W-1:0] idx_d,
  input  logic [XLEN-1:0]  data_d,
  output logic             out_valid,
  input  logic             out_ready,
  output act_e             act_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [XLEN-1:0]  data_q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      act_q     <= ACT_NONE;
      idx_q     <= '0;
      data_q    <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        act_q  <= act_d;
        idx_q  <= idx_d;
        data_q <= data_d;
      end
    end
  end

endmodule

// File: rtl/priv_cop_decoder.sv
module priv_cop_decoder
  import pcd_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_instr,
  input  logic             in_kernel,
  input  logic [XLEN-1:0]  in_src,
  output logic             rd_en,
  output logic [4:0]       rd_idx,
  input  logic [XLEN-1:0]  rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_dest,
  output logic             out_dest_vld,
  output logic             wr_req,
  output logic [4:0]       wr_idx,
  output logic [XLEN-1:0]  wr_data,
  output logic             wr_dword,
  output logic             eret_stb,
  output logic             llc_stb,
  output logic             tlbp_stb,
  output logic             tlbr_stb,
  output logic             tlbwi_stb,
  output logic             tlbwr_stb,
  output logic             cpu_unusable,
  output logic             illegal_op,
  output logic             cache_unsup
);

  act_e             act_d, act_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic [XLEN-1:0]  wdata_d, data_d, data_q;
  logic             fire;

  pcd_decode u_dec (
    .instr  (in_instr),
    .kernel (in_kernel),
    .act    (act_d),
    .idx    (idx_d)
  );

  pcd_sext #(.XLEN(XLEN), .NARROW_W(32)) u_sext (
    .src   (in_src),
    .dword (act_d == ACT_WR64),
    .wdata (wdata_d)
  );

  // Register read happens in the accept cycle; data is captured into the stage.
  assign rd_en  = in_valid && in_ready && (act_d == ACT_READ);
  assign rd_idx = idx_d;
  assign data_d = (act_d == ACT_READ) ? rd_data : wdata_d;

  pcd_stage #(.XLEN(XLEN)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .act_d     (act_d),
    .idx_d     (idx_d),
    .data_d    (data_d),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .act_q     (act_q),
    .idx_q     (idx_q),
    .data_q    (data_q)
  );

  assign fire         = out_valid && out_ready;
  assign out_dest_vld = out_valid && (act_q == ACT_READ);
  assign out_dest     = out_dest_vld ? data_q : '0;
  assign wr_idx       = idx_q;
  assign wr_data      = data_q;

  always_comb begin
    wr_req       = 1'b0;
    wr_dword     = 1'b0;
    eret_stb     = 1'b0;
    llc_stb      = 1'b0;
    tlbp_stb     = 1'b0;
    tlbr_stb     = 1'b0;
    tlbwi_stb    = 1'b0;
    tlbwr_stb    = 1'b0;
    cpu_unusable = 1'b0;
    illegal_op   = 1'b0;
    cache_unsup  = 1'b0;
    if (fire) begin
      unique case (act_q)
        ACT_WR32:     wr_req = 1'b1;
        ACT_WR64:     begin wr_req = 1'b1; wr_dword = 1'b1; end
        ACT_ERET:     begin eret_stb = 1'b1; llc_stb = 1'b1; end
        ACT_TLBP:     tlbp_stb = 1'b1;
        ACT_TLBR:     tlbr_stb = 1'b1;
        ACT_TLBWI:    tlbwi_stb = 1'b1;
        ACT_TLBWR:    tlbwr_stb = 1'b1;
        ACT_UNUSABLE: cpu_unusable = 1'b1;
        ACT_ILLEGAL:  illegal_op = 1'b1;
        ACT_CACHE:    cache_unsup = 1'b1;
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_kernel,
  input logic            rd_en,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_dest,
  input logic            out_dest_vld,
  input logic            wr_req,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_dword,
  input logic            eret_stb,
  input logic            llc_stb,
  input logic            tlbp_stb,
  input logic            tlbr_stb,
  input logic            tlbwi_stb,
  input logic            tlbwr_stb,
  input logic            cpu_unusable,
  input logic            illegal_op,
  input logic            cache_unsup
);

  logic any_pulse;
  assign any_pulse = wr_req | eret_stb | llc_stb | tlbp_stb | tlbr_stb | tlbwi_stb |
                     tlbwr_stb | cpu_unusable | illegal_op | cache_unsup;

  a_r1_no_read_in_user: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_kernel) |-> !rd_en);

  a_r1_user_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_kernel) |=> out_valid);

  a_r2_read_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (in_valid && in_ready && in_kernel));

  a_r3_narrow_is_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_dword) |-> ((wr_data[XLEN-1:31] == '0) || (wr_data[XLEN-1:31] == '1)));

  a_r5_llc_needs_eret: assert property (@(posedge clk) disable iff (!rst_n)
    llc_stb |-> eret_stb);

  a_r9_stall_holds_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  a_r9_stall_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_dest) && $stable(out_dest_vld)));

  a_r9_pulse_only_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    any_pulse |-> (out_valid && out_ready));

  a_r10_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_req, eret_stb, tlbp_stb, tlbr_stb, tlbwi_stb, tlbwr_stb,
              cpu_unusable, illegal_op, cache_unsup, out_dest_vld && out_ready}));

endmodule

bind priv_cop_decoder pcd_checker #(.XLEN(XLEN)) u_pcd_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_kernel    (in_kernel),
  .rd_en        (rd_en),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_dest     (out_dest),
  .out_dest_vld (out_dest_vld),
  .wr_req       (wr_req),
  .wr_data      (wr_data),
  .wr_dword     (wr_dword),
  .eret_stb     (eret_stb),
  .llc_stb      (llc_stb),
  .tlbp_stb     (tlbp_stb),
  .tlbr_stb     (tlbr_stb),
  .tlbwi_stb    (tlbwi_stb),
  .tlbwr_stb    (tlbwr_stb),
  .cpu_unusable (cpu_unusable),
  .illegal_op   (illegal_op),
  .cache_unsup  (cache_unsup)
);

// File: tb/test_priv_cop_decoder.sv
`timescale 1ns/1ps
module test_priv_cop_decoder;

  localparam int XLEN = 64;
  localparam int B_DVLD = 0, B_WR = 1, B_DW = 2, B_ERET = 3, B_LLC = 4, B_TP = 5,
                 B_TR = 6, B_TWI = 7, B_TWR = 8, B_UNU = 9, B_ILL = 10, B_CCH = 11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     in_instr = '0;
  logic            in_kernel = 1'b0;
  logic [XLEN-1:0] in_src = '0;
  logic            rd_en;
  logic [4:0]      rd_idx;
  logic [XLEN-1:0] rd_data;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [XLEN-1:0] out_dest;
  logic            out_dest_vld;
  logic            wr_req;
  logic [4:0]      wr_idx;
  logic [XLEN-1:0] wr_data;
  logic            wr_dword;
  logic            eret_stb, llc_stb, tlbp_stb, tlbr_stb, tlbwi_stb, tlbwr_stb;
  logic            cpu_unusable, illegal_op, cache_unsup;

  priv_cop_decoder #(.XLEN(XLEN)) i_priv_cop_decoder (.*);

  typedef struct {
    logic [11:0] act;
    logic [4:0]  idx;
    logic [63:0] data;
    string       tag;
  } exp_t;

  exp_t  q[$];
  int    errors = 0;
  int    checks = 0;
  bit    random_ready = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [63:0] regval(logic [4:0] i);
    return {32'hC0DE_0000 + 32'(i), 32'h8000_1000 + 32'(i)};
  endfunction

  assign rd_data = regval(rd_idx);

  function automatic logic [31:0] cop(logic [4:0] rs, logic [4:0] rd, logic [5:0] fn);
    return {6'b010000, rs, 5'd3, rd, 5'd0, fn};
  endfunction

  function automatic logic [31:0] cache_op(logic [1:0] tgt);
    return {6'b101111, 5'd4, 3'b101, tgt, 16'h0040};
  endfunction

  function automatic exp_t model(logic [31:0] ins, logic k, logic [63:0] src);
    exp_t e;
    logic [4:0] rs;
    logic [5:0] fn;
    e.act = '0; e.idx = ins[15:11]; e.data = '0; e.tag = "R7";
    rs = ins[25:21];
    fn = ins[5:0];
    if (!k) begin
      e.act[B_UNU] = 1'b1; e.tag = "R1";
    end else if (ins[31:26] == 6'b010000) begin
      if (rs[4]) begin
        case (fn)
          6'b011000: begin e.act[B_ERET] = 1'b1; e.act[B_LLC] = 1'b1; e.tag = "R5"; end
          6'b001000: begin e.act[B_TP]  = 1'b1; e.tag = "R6"; end
          6'b000001: begin e.act[B_TR]  = 1'b1; e.tag = "R6"; end
          6'b000010: begin e.act[B_TWI] = 1'b1; e.tag = "R6"; end
          6'b000110: begin e.act[B_TWR] = 1'b1; e.tag = "R6"; end
          default:   begin e.act[B_ILL] = 1'b1; e.tag = "R7"; end
        endcase
      end else begin
        case (rs)
          5'b00000, 5'b00001: begin
            e.act[B_DVLD] = 1'b1; e.data = regval(e.idx); e.tag = "R2";
          end
          5'b00100: begin
            e.act[B_WR] = 1'b1; e.data = {{32{src[31]}}, src[31:0]}; e.tag = "R3";
          end
          5'b00101: begin
            e.act[B_WR] = 1'b1; e.act[B_DW] = 1'b1; e.data = src; e.tag = "R4";
          end
          default: begin e.act[B_ILL] = 1'b1; e.tag = "R7"; end
        endcase
      end
    end else if (ins[31:26] == 6'b101111) begin
      e.act[B_CCH] = 1'b1; e.tag = "R8";
    end else begin
      e.act[B_ILL] = 1'b1; e.tag = "R8";
    end
    return e;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] act_now();
    logic [11:0] a;
    a = '0;
    a[B_DVLD] = out_dest_vld && out_ready;
    a[B_WR]   = wr_req;    a[B_DW]  = wr_dword;
    a[B_ERET] = eret_stb;  a[B_LLC] = llc_stb;
    a[B_TP]   = tlbp_stb;  a[B_TR]  = tlbr_stb;
    a[B_TWI]  = tlbwi_stb; a[B_TWR] = tlbwr_stb;
    a[B_UNU]  = cpu_unusable; a[B_ILL] = illegal_op; a[B_CCH] = cache_unsup;
    return a;
  endfunction

  // Consumer ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = random_ready ? lfsr[0] : 1'b1;
  end

  // Monitor: pops the scoreboard on each completed result handshake
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "result without accepted word", 64'(act_now()), 64'd0);
        end else begin
          exp_t e;
          logic [11:0] a;
          e = q.pop_front();
          a = act_now();
          chk(a == e.act, e.tag, "action pulses", 64'(a), 64'(e.act));
          chk($countones(a & ~(12'd1 << B_LLC) & ~(12'd1 << B_DW)) <= 1, "R10",
              "more than one action", 64'(a), 64'(e.act));
          if (e.act[B_DVLD])
            chk(out_dest == e.data, "R2", "out_dest", out_dest, e.data);
          if (e.act[B_WR]) begin
            chk(wr_idx == e.idx, e.tag, "wr_idx", 64'(wr_idx), 64'(e.idx));
            chk(wr_data == e.data, e.tag, "wr_data", wr_data, e.data);
          end
        end
      end else if (out_valid) begin
        chk(act_now() == '0, "R9", "pulse during stall", 64'(act_now()), 64'd0);
      end
    end
  end

  task automatic send(logic [31:0] ins, logic k, logic [63:0] src);
    exp_t e;
    e = model(ins, k, src);
    in_instr  = ins;
    in_kernel = k;
    in_src    = src;
    in_valid  = 1'b1;
    do @(negedge clk); while (!in_ready);
    chk(rd_en == e.act[B_DVLD], k ? "R2" : "R1", "rd_en", 64'(rd_en), 64'(e.act[B_DVLD]));
    if (e.act[B_DVLD])
      chk(rd_idx == e.idx, "R2", "rd_idx", 64'(rd_idx), 64'(e.idx));
    q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_all();
    // R1: user mode, every class
    send(cop(5'b00000, 5'd12, 6'd0), 1'b0, 64'h0);
    send(cop(5'b00100, 5'd12, 6'd0), 1'b0, 64'h55);
    send(cop(5'b10000, 5'd0, 6'b011000), 1'b0, 64'h0);
    send(cache_op(2'b01), 1'b0, 64'h0);
    // R2: move-from at index bounds, doubleword variant
    send(cop(5'b00000, 5'd0, 6'd0), 1'b1, 64'h0);
    send(cop(5'b00000, 5'd31, 6'd0), 1'b1, 64'h0);
    send(cop(5'b00001, 5'd9, 6'd0), 1'b1, 64'h0);
    // R3: both extension signs, junk in upper word
    send(cop(5'b00100, 5'd11, 6'd0), 1'b1, 64'hFFFF_FFFF_1234_5678);
    send(cop(5'b00100, 5'd13, 6'd0), 1'b1, 64'h0000_0000_8765_4321);
    // R4
    send(cop(5'b00101, 5'd14, 6'd0), 1'b1, 64'h0123_4567_89AB_CDEF);
    // R5, R6
    send(cop(5'b10000, 5'd0, 6'b011000), 1'b1, 64'h0);
    send(cop(5'b10000, 5'd0, 6'b001000), 1'b1, 64'h0);
    send(cop(5'b10000, 5'd0, 6'b000001), 1'b1, 64'h0);
    send(cop(5'b10000, 5'd0, 6'b000010), 1'b1, 64'h0);
    send(cop(5'b10000, 5'd0, 6'b000110), 1'b1, 64'h0);
    // R7: old return, branch, unknown function, unknown rs
    send(cop(5'b10000, 5'd0, 6'b010000), 1'b1, 64'h0);
    send(cop(5'b01000, 5'd0, 6'd0), 1'b1, 64'h0);
    send(cop(5'b10000, 5'd0, 6'b111111), 1'b1, 64'h0);
    send(cop(5'b00010, 5'd5, 6'd0), 1'b1, 64'h0);
    // R8: all cache targets, foreign opcode
    for (int t = 0; t < 4; t++) send(cache_op(2'(t)), 1'b1, 64'h0);
    send(32'h0000_0025, 1'b1, 64'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11", "out_valid in reset", 64'(out_valid), 64'd0);
    chk(act_now() == '0, "R11", "pulses in reset", 64'(act_now()), 64'd0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    random_ready = 1'b1;
    run_all();
    random_ready = 1'b0;
    run_all();
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule